// File: doc/BRIEF.md
# I/O-Read Idle-State Request Trap

This block sits on a processor's I/O read path and turns reads of a small group of power-management level registers into internal idle-state (C-state) requests. Each incoming read comes with a valid strobe and a 16-bit port address. The block compares the address against two inputs:

- a base address for the level-register group, and
- a range limit that firmware programs.

A read that falls in the trapped window is consumed. It produces a request that carries a target C-state code, a sub-state and an interrupt-break flag, and it never appears on the outgoing I/O path. Any other read is forwarded in the same cycle with its address unchanged.

The level number of a read is its address minus the base. Level 2 asks for C3 and level 3 asks for C6. Every higher level that the window admits is demoted to C6. An I/O read cannot carry a sub-state hint, so requests from this path always have sub-state zero and always have the break-on-interrupts-disabled control set. The trap needs no monitor arming or other setup before use.

The request is held in a one-entry slot and offered on a valid/ready handshake. While the slot is occupied the block de-asserts its read-ready output, so the next read stalls.

Top module: `iord_cstate_trap`

## Requirements
- R1: A trapped read whose level (address minus base, modulo 2^16) is 2 yields a request with C-state code 3.
- R2: A trapped read at level 3 yields a request with C-state code 6.
- R3: A trapped read at any level of 4 or more yields C-state code 6 (demotion).
- R4: A read is trapped exactly when 2 <= level <= 2 + range limit. Any other accepted read raises the forward strobe in the same cycle with the forward address equal to the read address. A trapped read never raises the forward strobe.
- R5: Every request carries sub-state 0 (4-bit field) and break flag 1.
- R6: The forward strobe and request-valid are never high in the same cycle.
- R7: While request-valid is high and request-ready is low, the request fields stay stable, read-ready is low, and a read presented meanwhile is neither forwarded nor trapped.
- R8: Request-valid rises in the cycle after the trapped read is accepted. It falls in the cycle after a cycle in which valid and ready are both high.
- R9: The first trapped read after reset is accepted with no prior setup. Reset clears a pending request.
- R10: A change of base or range limit applies to the very next read presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_valid_i | input | 1 | I/O read request strobe |
| rd_addr_i | input | 16 | I/O read port address |
| rd_ready_o | output | 1 | Block can accept a read this cycle |
| base_addr_i | input | 16 | Base address of the level-register group |
| range_lim_i | input | 4 | Firmware range limit: highest trapped level minus 2 |
| fwd_valid_o | output | 1 | Pass-through read strobe to the I/O path |
| fwd_addr_o | output | 16 | Pass-through read address |
| req_valid_o | output | 1 | Idle-state request valid |
| req_ready_i | input | 1 | Idle-state request accepted |
| req_cstate_o | output | 4 | Requested C-state code (3 or 6) |
| req_substate_o | output | 4 | Requested sub-state (always 0) |
| req_brk_o | output | 1 | Break-on-interrupts-disabled control (always 1) |

## Verification
A wrong window decode shows up in the same cycle as the read. The forward strobe is then high for a read that should be trapped, or low for one that should pass. A wrong slot state or level mapping shows up one cycle later, as a missing or stuck request-valid, a C-state code other than the one the level calls for, or read-ready staying low after the handshake. The bench sweeps every level offset around several bases, including one that wraps past address 0xFFFF, under every range limit. It compares each cycle against arithmetic expectations.

// File: rtl/ioct_pkg.sv
package ioct_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CST_C3 = 4'd3;
  localparam logic [CODE_W-1:0] CST_C6 = 4'd6;
  localparam logic [CODE_W-1:0] SUB_NONE = 4'd0;

  typedef struct packed {
    logic [CODE_W-1:0] cst;
    logic [CODE_W-1:0] sub;
    logic              brk;
  } cst_req_t;
endpackage

// File: rtl/ioct_rst_sync.sv
module ioct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/ioct_window_dec.sv
module ioct_window_dec #(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] lim_i,
  output logic          hit_o,
  output logic [AW-1:0] level_o
);
  localparam logic [AW-1:0] FIRST_LVL = AW'(2);

  logic [AW-1:0] off;
  logic [AW-1:0] span;
  logic [AW-1:0] lim_ext;

  always_comb begin
    off     = addr_i - base_i;
    span    = off - FIRST_LVL;
    lim_ext = AW'(lim_i);
    hit_o   = (off >= FIRST_LVL) && (span <= lim_ext);
    level_o = off;
  end
endmodule

// File: rtl/ioct_level_map.sv
module ioct_level_map #(
  parameter int AW = 16
) (
  input  logic [AW-1:0]         level_i,
  output ioct_pkg::cst_req_t    req_o
);
  import ioct_pkg::*;

  always_comb begin
    req_o.sub = SUB_NONE;
    req_o.brk = 1'b1;
    if (level_i == AW'(2)) req_o.cst = CST_C3;
    else                   req_o.cst = CST_C6;
  end
endmodule

// File: rtl/ioct_req_slot.sv
module ioct_req_slot (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  ioct_pkg::cst_req_t req_i,
  input  logic               ready_i,
  output logic               valid_o,
  output ioct_pkg::cst_req_t req_o
);
  import ioct_pkg::*;

  logic     vld_q, vld_d;
  cst_req_t req_q, req_d;
  logic     req_en;

  always_comb begin
    vld_d  = vld_q;
    req_en = 1'b0;
    req_d  = req_i;
    if (vld_q && ready_i) vld_d = 1'b0;
    if (load_i) begin
      vld_d  = 1'b1;
      req_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

  assign valid_o = vld_q;
  assign req_o   = req_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !ready_i) |=> (vld_q && $stable(req_q))) else $error("hold"); // R7
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && ready_i && !load_i) |=> !vld_q) else $error("drop"); // R8
endmodule

// File: rtl/iord_cstate_trap.sv
module iord_cstate_trap #(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_ready_o,
  input  logic [AW-1:0] base_addr_i,
  input  logic [LW-1:0] range_lim_i,
  output logic          fwd_valid_o,
  output logic [AW-1:0] fwd_addr_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [3:0]    req_cstate_o,
  output logic [3:0]    req_substate_o,
  output logic          req_brk_o
);
  import ioct_pkg::*;

  logic          rst_n_s;
  logic          hit;
  logic [AW-1:0] level;
  logic          accept;
  logic          load;
  cst_req_t      map_req;
  cst_req_t      slot_req;

  ioct_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  ioct_window_dec #(.AW(AW), .LW(LW)) u_dec (
    .addr_i(rd_addr_i), .base_i(base_addr_i), .lim_i(range_lim_i),
    .hit_o(hit), .level_o(level)
  );

  ioct_level_map #(.AW(AW)) u_map (.level_i(level), .req_o(map_req));

  ioct_req_slot u_slot (
    .clk(clk), .rst_n(rst_n_s), .load_i(load), .req_i(map_req),
    .ready_i(req_ready_i), .valid_o(req_valid_o), .req_o(slot_req)
  );

  always_comb begin
    rd_ready_o  = rst_n_s && !req_valid_o;
    accept      = rd_valid_i && rd_ready_o;
    load        = accept && hit;
    fwd_valid_o = accept && !hit;
    fwd_addr_o  = rd_addr_i;
  end

  assign req_cstate_o   = slot_req.cst;
  assign req_substate_o = slot_req.sub;
  assign req_brk_o      = slot_req.brk;

  AST_FWD_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(fwd_valid_o && req_valid_o)) else $error("excl"); // R6
  AST_TRAP_RAISE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_valid_i && rd_ready_o && !fwd_valid_o) |=> req_valid_o) else $error("raise"); // R8
  AST_REQ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid_o |-> (req_substate_o == 4'd0 && req_brk_o)) else $error("fields"); // R5
  AST_REQ_CODE: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid_o |-> (req_cstate_o == 4'd3 || req_cstate_o == 4'd6)) else $error("code"); // R2
  AST_STALL_NOFWD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid_o && !req_ready_i) |=> !fwd_valid_o) else $error("stall"); // R7
endmodule

// File: tb/tb_iord_cstate_trap.sv
module tb_iord_cstate_trap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [15:0] rd_addr_i = '0;
  logic        rd_ready_o;
  logic [15:0] base_addr_i = 16'h0400;
  logic [3:0]  range_lim_i = 4'd0;
  logic        fwd_valid_o;
  logic [15:0] fwd_addr_o;
  logic        req_valid_o;
  logic        req_ready_i = 1'b1;
  logic [3:0]  req_cstate_o;
  logic [3:0]  req_substate_o;
  logic        req_brk_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  iord_cstate_trap dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_trap(input logic [15:0] a, input logic [15:0] b, input logic [3:0] l);
    logic [15:0] off;
    off = a - b;
    return (off >= 16'd2) && ((off - 16'd2) <= {12'd0, l});
  endfunction

  function automatic int exp_code(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] off;
    off = a - b;
    return (off == 16'd2) ? 3 : 6;
  endfunction

  // One read with ready high; checks forward path, request and release.
  task automatic do_read(input logic [15:0] a);
    bit t;
    int c;
    t = exp_trap(a, base_addr_i, range_lim_i);
    c = exp_code(a, base_addr_i);
    @(negedge clk);
    rd_valid_i = 1'b1;
    rd_addr_i  = a;
    #1;
    chk(fwd_valid_o == !t, "R4 fwd", int'(fwd_valid_o), int'(!t));
    if (!t) chk(fwd_addr_o == a, "R4 addr", int'(fwd_addr_o), int'(a));
    chk(!(fwd_valid_o && req_valid_o), "R6", int'(req_valid_o), 0);
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk(req_valid_o == t, "R8 rise", int'(req_valid_o), int'(t));
    if (t) begin
      if (c == 3) chk(req_cstate_o == 4'd3, "R1", int'(req_cstate_o), 3);
      else if ((a - base_addr_i) == 16'd3) chk(req_cstate_o == 4'd6, "R2", int'(req_cstate_o), 6);
      else chk(req_cstate_o == 4'd6, "R3", int'(req_cstate_o), 6);
      chk(req_substate_o == 4'd0 && req_brk_o, "R5", int'({req_substate_o, req_brk_o}), 1);
      @(negedge clk);
      chk(!req_valid_o && rd_ready_o, "R8 drop", int'(req_valid_o), 0);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [3];
    bases[0] = 16'h0400;
    bases[1] = 16'h0815;
    bases[2] = 16'hFFFB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req_valid_o && rd_ready_o && !fwd_valid_o, "R9 reset", int'(req_valid_o), 0);

    // First trap after reset, no setup.
    range_lim_i = 4'd3;
    do_read(16'h0402);

    // Sweep every base, every limit, offsets -2..21.
    for (int b = 0; b < 3; b++) begin
      base_addr_i = bases[b];
      for (int l = 0; l < 16; l++) begin
        range_lim_i = 4'(l);
        for (int o = -2; o < 22; o++) do_read(bases[b] + 16'(o));
      end
    end

    // R10: config change applies to the next read.
    base_addr_i = 16'h0100; range_lim_i = 4'd0;
    do_read(16'h0103);
    range_lim_i = 4'd1;
    do_read(16'h0103);
    base_addr_i = 16'h0101;
    @(negedge clk);
    rd_valid_i = 1'b1; rd_addr_i = 16'h0103;
    #1;
    chk(!fwd_valid_o, "R10 new base traps", int'(fwd_valid_o), 0);
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk(req_valid_o && req_cstate_o == 4'd3, "R10 level2 C3", int'(req_cstate_o), 3);
    @(negedge clk);

    // R7: stall with ready low.
    base_addr_i = 16'h0400; range_lim_i = 4'd5;
    req_ready_i = 1'b0;
    @(negedge clk);
    rd_valid_i = 1'b1; rd_addr_i = 16'h0403;
    @(negedge clk);
    rd_addr_i = 16'h0050;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(req_valid_o && req_cstate_o == 4'd6, "R7 hold", int'(req_cstate_o), 6);
      chk(!rd_ready_o, "R7 ready low", int'(rd_ready_o), 0);
      chk(!fwd_valid_o, "R7 no fwd", int'(fwd_valid_o), 0);
      @(negedge clk);
    end
    rd_valid_i = 1'b0;
    req_ready_i = 1'b1;
    @(negedge clk);
    chk(!req_valid_o && rd_ready_o, "R8 release", int'(req_valid_o), 0);
    do_read(16'h0050);

    // R9: reset clears a pending request.
    req_ready_i = 1'b0;
    @(negedge clk);
    rd_valid_i = 1'b1; rd_addr_i = 16'h0402;
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk(req_valid_o, "R9 pending", int'(req_valid_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!req_valid_o, "R9 cleared", int'(req_valid_o), 0);
    rst_n = 1'b1;
    req_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    do_read(16'h0404);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule